// File: doc/BRIEF.md
# Split-Operand Multiply Sequencer

This block performs one unsigned 64 by 64 bit integer multiply on a single 32 by 32 bit multiplier. Once an issue strobe is accepted, the block drives a half-select output for each source operand over four consecutive execute cycles. The register file answers on the matching 32-bit read port in the same cycle. One partial product is formed per cycle, and the four partial products are summed in a pipeline. The lower 64 bits of the product come back through a 32-bit write port as two words on separate cycles: first the low word, then the high word. A status bit reports whether the upper 64 bits of the full 128-bit product are non-zero.

The issue cycle is execute cycle E1. The multiplier is occupied from E1 to E4. For that time a busy output refuses new issue strobes, and the requester keeps its strobe high until the issue is taken. The low result word retires on E9 and the high word on E10, so a consumer has the whole result from the cycle after E10. Operations accepted four cycles apart overlap inside the pipeline and retire in the order they were issued.

Top module: `split_mul_seq`

## Requirements
- R1: An issue strobe seen while busy is low starts an operation in that cycle (E1). Busy is then high for exactly the three following cycles (E2, E3, E4) and low again on E5. An issue strobe while busy is high starts nothing, so two accepted issues are at least four cycles apart.
- R2: The half selects use 1 to mean the upper 32 bits. Over E1, E2, E3, E4, src1_hi_o reads 0,0,1,1 and src2_hi_o reads 0,1,0,1. Both are 0 in every other cycle. The data inputs are sampled in the same cycle as the select.
- R3: On E9 the write port shows wr_en_o=1, wr_hi_o=0, and wr_data_o equal to bits 31:0 of the unsigned product.
- R4: On E10 the write port shows wr_en_o=1, wr_hi_o=1, and wr_data_o equal to bits 63:32 of the product.
- R5: ovf_o takes a new value on E9: 1 if bits 127:64 of the 128-bit product are non-zero, else 0. It holds that value until the next E9 or a reset.
- R6: wr_en_o is low in every cycle that is not the E9 or E10 of an accepted operation.
- R7: Operations accepted four cycles apart each retire their own correct 64-bit result, in issue order.
- R8: Reset is synchronous and active high. In the cycle after reset, busy_o, wr_en_o and ovf_o are low. Any operation in flight is discarded, and no write occurs until a new issue. An issue strobe during the reset cycle is ignored.
- R9: Values on the data inputs outside an operation's own read slots (E1 to E4) have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue request, held by the requester until accepted |
| busy_o | output | 1 | Multiplier occupied; an issue this cycle is refused |
| src1_hi_o | output | 1 | Half select for source 1 (1 = upper 32 bits) |
| src1_data_i | input | 32 | Selected half of source 1 |
| src2_hi_o | output | 1 | Half select for source 2 (1 = upper 32 bits) |
| src2_data_i | input | 32 | Selected half of source 2 |
| wr_en_o | output | 1 | Destination write strobe |
| wr_hi_o | output | 1 | Destination half being written (1 = upper word) |
| wr_data_o | output | 32 | Destination write data |
| ovf_o | output | 1 | Product exceeded 64 bits (status) |

## Verification
The hardest case is two overlapping operations. The second operation reads its operands, and overwrites the shared accumulator, while the first is still moving towards writeback. A refused issue then has to be re-timed onto the exact cycle the unit frees. The stimulus table places operations exactly four cycles apart, and also raises a request two cycles after an issue. That request is held through the busy window and lands at the four-cycle spacing. The bench drives scrambled values on the data ports in every cycle outside an operation's read slots, so a read on the wrong cycle or the wrong half corrupts the result. A reset applied after the last operand read, but before writeback, checks that the partly finished result never reaches the write port.

// File: rtl/smseq_pkg.sv
package smseq_pkg;

  // Read slot of an operation: which operand halves meet in the multiplier.
  // bit 1 picks source 1 half, bit 0 picks source 2 half (1 = upper).
  typedef enum logic [1:0] {
    PH_LL = 2'b00,
    PH_LH = 2'b01,
    PH_HL = 2'b10,
    PH_HH = 2'b11
  } smseq_ph_e;

  function automatic logic src1_takes_hi(input smseq_ph_e p);
    return p[1];
  endfunction

  function automatic logic src2_takes_hi(input smseq_ph_e p);
    return p[0];
  endfunction

  // Weight of a partial product, counted in half-operand widths.
  function automatic int unsigned weight_halves(input smseq_ph_e p);
    case (p)
      PH_LL:   return 0;
      PH_LH:   return 1;
      PH_HL:   return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/smseq_fetch.sv
module smseq_fetch
  import smseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      issue_i,
  output logic      busy_o,
  output logic      issue_acc_o,
  output logic      rd_en_o,
  output smseq_ph_e ph_o,
  output logic      sel1_o,
  output logic      sel2_o
);

  logic      act_q;
  smseq_ph_e ph_q;

  assign busy_o      = act_q;
  assign issue_acc_o = issue_i & ~act_q & ~rst;
  assign rd_en_o     = issue_acc_o | act_q;
  assign ph_o        = act_q ? ph_q : PH_LL;
  assign sel1_o      = rd_en_o & src1_takes_hi(ph_o);
  assign sel2_o      = rd_en_o & src2_takes_hi(ph_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      ph_q  <= PH_LL;
    end else if (issue_acc_o) begin
      act_q <= 1'b1;
      ph_q  <= PH_LH;
    end else if (act_q) begin
      if (ph_q == PH_HH) begin
        act_q <= 1'b0;
        ph_q  <= PH_LL;
      end else begin
        ph_q <= smseq_ph_e'(ph_q + 2'd1);
      end
    end
  end

  p_busy_after_issue_r1: assert property (@(posedge clk) disable iff (rst)
    issue_acc_o |=> busy_o);

  p_busy_ends_r1: assert property (@(posedge clk) disable iff (rst)
    (busy_o && ph_o == PH_HH) |=> !busy_o);

  p_sel_second_r2: assert property (@(posedge clk) disable iff (rst)
    issue_acc_o |=> (!sel1_o && sel2_o));

  p_sel_third_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !sel1_o && sel2_o) |=> (sel1_o && !sel2_o));

  p_sel_fourth_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && sel1_o && !sel2_o) |=> (sel1_o && sel2_o));

endmodule

// File: rtl/smseq_mac.sv
module smseq_mac
  import smseq_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en_i,
  input  smseq_ph_e             ph_i,
  input  logic [HALF_W-1:0]     a_i,
  input  logic [HALF_W-1:0]     b_i,
  output logic                  fin_v_o,
  output logic [2*HALF_W-1:0]   fin_res_o,
  output logic                  fin_ovf_o
);

  localparam int unsigned PP_W  = 2 * HALF_W;
  localparam int unsigned ACC_W = 4 * HALF_W;
  localparam int unsigned RES_W = 2 * HALF_W;

  function automatic logic [PP_W-1:0] mul_halves(input logic [HALF_W-1:0] x,
                                                 input logic [HALF_W-1:0] y);
    return {{HALF_W{1'b0}}, x} * {{HALF_W{1'b0}}, y};
  endfunction

  function automatic logic [ACC_W-1:0] place_pp(input logic [PP_W-1:0] pp,
                                                input smseq_ph_e p);
    return {{(ACC_W-PP_W){1'b0}}, pp} << (HALF_W * weight_halves(p));
  endfunction

  logic [PP_W-1:0]  pp_q;
  smseq_ph_e        pp_ph_q;
  logic             pp_v_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] contrib;
  logic [ACC_W-1:0] acc_sum;

  always_ff @(posedge clk) begin
    if (rst) pp_v_q <= 1'b0;
    else     pp_v_q <= rd_en_i;
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) begin
      pp_q    <= mul_halves(a_i, b_i);
      pp_ph_q <= ph_i;
    end
  end

  assign contrib = place_pp(pp_q, pp_ph_q);
  assign acc_sum = acc_q + contrib;

  always_ff @(posedge clk) begin
    if (pp_v_q) acc_q <= (pp_ph_q == PH_LL) ? contrib : acc_sum;
  end

  assign fin_v_o   = pp_v_q && (pp_ph_q == PH_HH);
  assign fin_res_o = acc_sum[RES_W-1:0];
  assign fin_ovf_o = |acc_sum[ACC_W-1:RES_W];

  p_first_slot_r7: assert property (@(posedge clk) disable iff (rst)
    (pp_v_q && !$past(pp_v_q)) |-> (pp_ph_q == PH_LL));

  p_slot_ll_lh_r7: assert property (@(posedge clk) disable iff (rst)
    (pp_v_q && pp_ph_q == PH_LL) |=> (pp_v_q && pp_ph_q == PH_LH));

  p_slot_lh_hl_r7: assert property (@(posedge clk) disable iff (rst)
    (pp_v_q && pp_ph_q == PH_LH) |=> (pp_v_q && pp_ph_q == PH_HL));

  p_slot_hl_hh_r7: assert property (@(posedge clk) disable iff (rst)
    (pp_v_q && pp_ph_q == PH_HL) |=> (pp_v_q && pp_ph_q == PH_HH));

endmodule

// File: rtl/smseq_dly.sv
module smseq_dly #(
  parameter int unsigned W    = 65,
  parameter int unsigned NSTG = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] d_o
);

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    logic         v_q;
    logic [W-1:0] d_q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= v_i;
      end
      always_ff @(posedge clk) begin
        if (v_i) d_q <= d_i;
      end
    end else begin : g_link
      always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= g_stg[g-1].v_q;
      end
      always_ff @(posedge clk) begin
        if (g_stg[g-1].v_q) d_q <= g_stg[g-1].d_q;
      end
    end
  end

  assign v_o = g_stg[NSTG-1].v_q;
  assign d_o = g_stg[NSTG-1].d_q;

endmodule

// File: rtl/smseq_retire.sv
module smseq_retire #(
  parameter int unsigned HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_v_i,
  input  logic [2*HALF_W-1:0] in_res_i,
  input  logic                in_ovf_i,
  output logic                wr_en_o,
  output logic                wr_hi_o,
  output logic [HALF_W-1:0]   wr_data_o,
  output logic                ovf_o
);

  logic              hi_v_q;
  logic [HALF_W-1:0] hi_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o <= 1'b0;
      wr_hi_o <= 1'b0;
      ovf_o   <= 1'b0;
      hi_v_q  <= 1'b0;
    end else if (in_v_i) begin
      wr_en_o <= 1'b1;
      wr_hi_o <= 1'b0;
      ovf_o   <= in_ovf_i;
      hi_v_q  <= 1'b1;
    end else if (hi_v_q) begin
      wr_en_o <= 1'b1;
      wr_hi_o <= 1'b1;
      hi_v_q  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      wr_hi_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_v_i) begin
      wr_data_o <= in_res_i[HALF_W-1:0];
      hi_d_q    <= in_res_i[2*HALF_W-1:HALF_W];
    end else if (hi_v_q) begin
      wr_data_o <= hi_d_q;
    end
  end

  p_hi_follows_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && !wr_hi_o) |=> (wr_en_o && wr_hi_o));

  p_hi_needs_lo_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_hi_o) |-> $past(wr_en_o && !wr_hi_o));

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    !(in_v_i && hi_v_q));

  p_status_on_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ovf_o) && !$past(rst)) |-> (wr_en_o && !wr_hi_o));

endmodule

// File: rtl/split_mul_seq.sv
module split_mul_seq
  import smseq_pkg::*;
#(
  parameter int unsigned HALF_W      = 32,
  parameter int unsigned WB_LO_CYCLE = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  output logic              busy_o,
  output logic              src1_hi_o,
  input  logic [HALF_W-1:0] src1_data_i,
  output logic              src2_hi_o,
  input  logic [HALF_W-1:0] src2_data_i,
  output logic              wr_en_o,
  output logic              wr_hi_o,
  output logic [HALF_W-1:0] wr_data_o,
  output logic              ovf_o
);

  // The last partial product is summed on E5; the low word leaves a register on E9.
  localparam int unsigned RES_W = 2 * HALF_W;
  localparam int unsigned NSTG  = WB_LO_CYCLE - 6;
  localparam int unsigned PIPE_W = RES_W + 1;

  logic                issue_acc;
  logic                rd_en;
  smseq_ph_e           rd_ph;
  logic                fin_v;
  logic [RES_W-1:0]    fin_res;
  logic                fin_ovf;
  logic                wb_v;
  logic [PIPE_W-1:0]   wb_d;

  smseq_fetch u_fetch (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (issue_i),
    .busy_o      (busy_o),
    .issue_acc_o (issue_acc),
    .rd_en_o     (rd_en),
    .ph_o        (rd_ph),
    .sel1_o      (src1_hi_o),
    .sel2_o      (src2_hi_o)
  );

  smseq_mac #(.HALF_W(HALF_W)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .rd_en_i   (rd_en),
    .ph_i      (rd_ph),
    .a_i       (src1_data_i),
    .b_i       (src2_data_i),
    .fin_v_o   (fin_v),
    .fin_res_o (fin_res),
    .fin_ovf_o (fin_ovf)
  );

  smseq_dly #(.W(PIPE_W), .NSTG(NSTG)) u_dly (
    .clk (clk),
    .rst (rst),
    .v_i (fin_v),
    .d_i ({fin_ovf, fin_res}),
    .v_o (wb_v),
    .d_o (wb_d)
  );

  smseq_retire #(.HALF_W(HALF_W)) u_retire (
    .clk       (clk),
    .rst       (rst),
    .in_v_i    (wb_v),
    .in_res_i  (wb_d[RES_W-1:0]),
    .in_ovf_i  (wb_d[RES_W]),
    .wr_en_o   (wr_en_o),
    .wr_hi_o   (wr_hi_o),
    .wr_data_o (wr_data_o),
    .ovf_o     (ovf_o)
  );

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!wr_en_o && !busy_o && !ovf_o));

  p_no_issue_in_reset_r8: assert property (@(posedge clk)
    rst |-> !issue_acc);

endmodule

// File: tb/split_mul_seq_tb_top.sv
module split_mul_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [7:0]  gap;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{64'd3,                  64'd5,                  8'd0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd4},
    '{64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 8'd4},
    '{64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 8'd2},
    '{64'hFFFF_FFFF_0000_0000, 64'd2,                  8'd4},
    '{64'd0,                  64'hFFFF_FFFF_FFFF_FFFF, 8'd7},
    '{64'h8000_0000_0000_0000, 64'd2,                  8'd4},
    '{64'h0000_0000_DEAD_BEEF, 64'h0000_CAFE_0000_0000, 8'd5},
    '{64'd7,                  64'h0000_0000_FFFF_FFFF, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [31:0] d1 = '0;
  logic [31:0] d2 = '0;
  logic        busy, sel1, sel2, wr_en, wr_hi, ovf;
  logic [31:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_mul_seq dut_i (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (issue),
    .busy_o      (busy),
    .src1_hi_o   (sel1),
    .src1_data_i (d1),
    .src2_hi_o   (sel2),
    .src2_data_i (d2),
    .wr_en_o     (wr_en),
    .wr_hi_o     (wr_hi),
    .wr_data_o   (wr_data),
    .ovf_o       (ovf)
  );

  int          n_run = 0;
  int          n_fail = 0;
  int          cyc = 0;
  int          nops = 0;
  int          last_acc = -100;
  logic [63:0] op_a [32];
  logic [63:0] op_b [32];
  int          op_t [32];
  bit          op_b2b [32];
  logic        exp_ovf = 1'b0;
  logic [31:0] lo_seen = '0;
  logic [63:0] cur_a = '0;
  logic [63:0] cur_b = '0;
  bit          req = 1'b0;
  bit          rst_want = 1'b1;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic logic [127:0] full_prod(input logic [63:0] a, input logic [63:0] b);
    return {64'd0, a} * {64'd0, b};
  endfunction

  // One clock cycle: drive inputs after the falling edge, then check outputs.
  task automatic tick();
    bit          busy_m = 1'b0;
    bit          acc;
    bit          found = 1'b0;
    logic        s1m = 1'b0;
    logic        s2m = 1'b0;
    logic [31:0] g;
    logic [127:0] p;
    @(negedge clk);
    rst = rst_want;
    for (int j = 0; j < nops; j++) begin
      int k = cyc - op_t[j] + 1;
      if (k >= 2 && k <= 4) busy_m = 1'b1;
    end
    acc   = req && !busy_m && !rst;
    issue = req;
    if (acc) begin
      op_a[nops]   = cur_a;
      op_b[nops]   = cur_b;
      op_t[nops]   = cyc;
      op_b2b[nops] = (cyc - last_acc == 4);
      last_acc     = cyc;
      nops++;
      req = 1'b0;
    end
    // Scrambled data outside any read slot (R9).
    g  = 32'hC3C3_0000 ^ cyc;
    d1 = g;
    d2 = ~g;
    for (int j = 0; j < nops; j++) begin
      int k = cyc - op_t[j] + 1;
      if (k >= 1 && k <= 4) begin
        d1  = (k <= 2) ? op_a[j][31:0] : op_a[j][63:32];
        d2  = (k == 1 || k == 3) ? op_b[j][31:0] : op_b[j][63:32];
        s1m = (k >= 3);
        s2m = (k == 2 || k == 4);
      end
    end
    #1;
    chk("R1 busy", {63'd0, busy}, {63'd0, busy_m});
    chk("R2 selects", {62'd0, sel1, sel2}, {62'd0, s1m, s2m});
    for (int j = 0; j < nops; j++) begin
      int k = cyc - op_t[j] + 1;
      p = full_prod(op_a[j], op_b[j]);
      if (k == 9) begin
        found = 1'b1;
        chk("R3 low write", {30'd0, wr_en, wr_hi, wr_data}, {30'd0, 1'b1, 1'b0, p[31:0]});
        exp_ovf = |p[127:64];
        lo_seen = wr_data;
      end else if (k == 10) begin
        found = 1'b1;
        chk("R4 high write", {30'd0, wr_en, wr_hi, wr_data}, {30'd0, 1'b1, 1'b1, p[63:32]});
        chk(op_b2b[j] ? "R7 overlapped result" : "R9 result", {wr_data, lo_seen}, p[63:0]);
      end
    end
    if (!found) chk("R6 idle write", {63'd0, wr_en}, 64'd0);
    chk("R5 status", {63'd0, ovf}, {63'd0, exp_ovf});
    if (rst) begin
      nops    = 0;
      exp_ovf = 1'b0;
    end
    cyc++;
  endtask

  task automatic run_op(input logic [63:0] a, input logic [63:0] b);
    cur_a = a;
    cur_b = b;
    req   = 1'b1;
    while (req) tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_want = 1'b0;
    // R8: state right after reset
    chk("R8 reset state", {61'd0, busy, wr_en, ovf}, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (i > 0) begin
        while (cyc < last_acc + int'(VECS[i].gap)) tick();
      end
      run_op(VECS[i].a, VECS[i].b);
    end
    repeat (14) tick();

    // Directed: set status, then reset an operation between its reads and writeback (R8).
    run_op(64'h8000_0000_0000_0000, 64'd4);
    repeat (10) tick();
    chk("R5 status set", {63'd0, ovf}, 64'd1);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd3);
    repeat (4) tick();
    rst_want = 1'b1;
    cur_a = 64'd9;
    cur_b = 64'd9;
    req   = 1'b1;
    tick();
    req      = 1'b0;
    rst_want = 1'b0;
    tick();
    chk("R8 after reset", {61'd0, busy, wr_en, ovf}, 64'd0);
    repeat (12) tick();

    run_op(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF);
    repeat (12) tick();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule